// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block produces the word a parallel NOR flash puts on its data bus when the host polls it while an internal program or erase runs, or while an erase is suspended. It also produces the ready/busy level. The caller supplies the current operation state, the data read from the array at the polled address, a flag that says whether that address lies inside the suspended erase region, bit 7 of the word being programmed, and a one-cycle read strobe for each host read. When the device is idle, or when it is suspended and the host reads outside the suspended region, the array word passes through unchanged.

In the status states, bits 7, 6 and 2 of the array word are replaced and every other bit passes through. Bit 7 is the polling bit: it is the inverted data bit during a program and a constant during an erase. Bits 6 and 2 are toggle bits. Each one flips on every read strobe while its toggling is enabled, and it does not change on clock cycles that carry no strobe. Both toggle bits restart from 0 whenever the operation state changes, so the first read of a new operation always returns a known value.

Operation state codes on `op_state_i`: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend. Codes 5 to 7 behave as idle.

Top module: `flash_wstat`

## Requirements
- R1: With op_state_i=0 (idle), dq_o equals array_data_i and ready_o is 1.
- R2: With op_state_i=1 (program), dq_o[7] is the inverse of prog_dq7_i and ready_o is 0.
- R3: With op_state_i=1, dq_o[6] changes value once per read strobe and holds across cycles without a strobe. dq_o[2] reads 0.
- R4: With op_state_i=2 (erase), dq_o[7] is 0, dq_o[6] and dq_o[2] each flip once per read strobe, and ready_o is 0.
- R5: With op_state_i=3 (suspended) and in_susp_i=1, dq_o[7] and dq_o[6] are 1, dq_o[2] flips once per read strobe, and ready_o is 1.
- R6: With op_state_i=3 and in_susp_i=0, dq_o equals array_data_i and ready_o is 1. Such reads do not advance the dq_o[2] toggle.
- R7: With op_state_i=4 (program during suspend), dq_o[7] is the inverse of prog_dq7_i, dq_o[6] flips once per read strobe, dq_o[2] reads 0, and ready_o is 0.
- R8: In the first cycle after op_state_i changes, both toggle bits read 0. ready_o follows the new state in that same cycle.
- R9: When the state returns to 0 after an operation, dq_o again equals array_data_i on every read, with no toggling.
- R10: During and right after reset, ready_o is 1 and both toggle states are 0.
- R11: In the status states, every bit of dq_o other than 7, 6 and 2 equals the matching bit of array_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_state_i | input | 3 | Operation state code (0 to 4) |
| rd_stb_i | input | 1 | One-cycle strobe for each host read |
| in_susp_i | input | 1 | Polled address lies in the suspended region |
| prog_dq7_i | input | 1 | Bit 7 of the word being programmed |
| array_data_i | input | DW | Array word at the polled address |
| dq_o | output | DW | Word returned to the host |
| ready_o | output | 1 | 1 when ready, 0 while an operation is busy |

## Verification
Each toggle bit depends on one flip-flop. A wrong value in it shows up on the very next strobed read, as two equal values in a row or as a nonzero first read after a state change. The bench reads more than once after every state change so that it catches both faults. Errors in decoding the polling bit and ready/busy are purely combinational and show in the cycle the state is applied. The bench places idle cycles between strobes so that a toggle driven by the clock instead of the strobe shows within one read.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_SUSP_PROG = 3'd4
  } op_e;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TGL_BIT  = 6;
  localparam int unsigned AUX_BIT  = 2;
endpackage

// File: rtl/flash_wstat_tgl.sv
module flash_wstat_tgl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  input  logic rd_i,
  output logic q_o
);
  logic q_q;
  logic step;

  assign step = en_i & rd_i;
  // a state change forces 0 on the bus in the same cycle
  assign q_o  = restart_i ? 1'b0 : q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= 1'b0;
    else if (restart_i || step) q_q <= q_o ^ step;
  end
endmodule

// File: rtl/flash_wstat_mux.sv
module flash_wstat_mux
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  op_e           op_i,
  input  logic          in_susp_i,
  input  logic          prog_dq7_i,
  input  logic [DW-1:0] array_data_i,
  input  logic          t6_i,
  input  logic          t2_i,
  output logic [DW-1:0] dq_o,
  output logic          ready_o
);
  logic [DW-1:0] stat;
  logic          poll;
  logic          b6;
  logic          show_stat;

  always_comb begin
    poll      = 1'b0;
    b6        = t6_i;
    show_stat = 1'b1;
    ready_o   = 1'b1;
    unique case (op_i)
      OP_PROG, OP_SUSP_PROG: begin
        poll    = ~prog_dq7_i;
        ready_o = 1'b0;
      end
      OP_ERASE: begin
        poll    = 1'b0;
        ready_o = 1'b0;
      end
      OP_SUSP: begin
        poll      = 1'b1;
        b6        = 1'b1;
        show_stat = in_susp_i;
      end
      default: show_stat = 1'b0;
    endcase
  end

  always_comb begin
    stat           = array_data_i;
    stat[POLL_BIT] = poll;
    stat[TGL_BIT]  = b6;
    stat[AUX_BIT]  = t2_i;
  end

  assign dq_o = show_stat ? stat : array_data_i;
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_state_i,
  input  logic          rd_stb_i,
  input  logic          in_susp_i,
  input  logic          prog_dq7_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] dq_o,
  output logic          ready_o
);
  op_e  op, op_q;
  logic restart;
  logic en6, en2;
  logic t6, t2;

  assign op = op_e'(op_state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= OP_IDLE;
    else         op_q <= op;
  end

  assign restart = (op != op_q);
  assign en6 = (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SUSP_PROG);
  assign en2 = (op == OP_ERASE) || ((op == OP_SUSP) && in_susp_i);

  flash_wstat_tgl u_tgl6 (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .en_i(en6), .rd_i(rd_stb_i), .q_o(t6)
  );

  flash_wstat_tgl u_tgl2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .en_i(en2), .rd_i(rd_stb_i), .q_o(t2)
  );

  flash_wstat_mux #(.DW(DW)) u_mux (
    .op_i(op), .in_susp_i(in_susp_i), .prog_dq7_i(prog_dq7_i),
    .array_data_i(array_data_i), .t6_i(t6), .t2_i(t2),
    .dq_o(dq_o), .ready_o(ready_o)
  );
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_state_i,
  input logic          rd_stb_i,
  input logic          in_susp_i,
  input logic          prog_dq7_i,
  input logic [DW-1:0] array_data_i,
  input logic [DW-1:0] dq_o,
  input logic          ready_o
);
  p_idle_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd0) |-> (dq_o == array_data_i) && ready_o);

  p_prog_poll_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd1) |-> (dq_o[7] == !prog_dq7_i) && !ready_o);

  p_prog_aux_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd1) |-> !dq_o[2]);

  p_erase_tgl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd2 && rd_stb_i) |=>
      (op_state_i != 3'd2) || (dq_o[6] != $past(dq_o[6])));

  p_susp_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd3 && in_susp_i) |-> dq_o[7] && dq_o[6] && ready_o);

  p_susp_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd3 && !in_susp_i) |-> (dq_o == array_data_i) && ready_o);

  p_sprog_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i == 3'd4) |-> !ready_o && (dq_o[7] == !prog_dq7_i));

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_state_i != $past(op_state_i) && op_state_i == 3'd2) |->
      !dq_o[6] && !dq_o[2]);
endmodule

bind flash_wstat flash_wstat_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_state_i(op_state_i),
  .rd_stb_i(rd_stb_i), .in_susp_i(in_susp_i), .prog_dq7_i(prog_dq7_i),
  .array_data_i(array_data_i), .dq_o(dq_o), .ready_o(ready_o)
);

// File: tb/tb_flash_wstat.sv
module tb_flash_wstat;
  localparam int DW = 16;
  localparam logic [DW-1:0] ARR = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_state = 3'd0;
  logic          rd_stb = 1'b0;
  logic          in_susp = 1'b0;
  logic          prog_dq7 = 1'b0;
  logic [DW-1:0] array_data = ARR;
  logic [DW-1:0] dq;
  logic          ready;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_wstat #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .op_state_i(op_state), .rd_stb_i(rd_stb),
    .in_susp_i(in_susp), .prog_dq7_i(prog_dq7), .array_data_i(array_data),
    .dq_o(dq), .ready_o(ready)
  );

  function automatic logic [DW-1:0] stat(input logic b7, input logic b6, input logic b2);
    logic [DW-1:0] w;
    w = ARR; w[7] = b7; w[6] = b6; w[2] = b2;
    return w;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic [2:0] op);
    @(negedge clk); op_state = op; rd_stb = 1'b0;
  endtask

  task automatic do_read(output logic [DW-1:0] d, output logic r);
    @(negedge clk); rd_stb = 1'b1;
    #3; d = dq; r = ready;
    @(posedge clk); #1; rd_stb = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    #3;
    chk("R10 ready in reset", {15'd0, ready}, 16'd1);
    chk("R10 idle data in reset", dq, ARR);
    @(negedge clk); rst_n = 1'b1;
    #3;
    chk("R10 ready after reset", {15'd0, ready}, 16'd1);
  endtask

  task automatic t_idle;
    logic [DW-1:0] d; logic r;
    set_op(3'd0);
    do_read(d, r);
    chk("R1 idle data", d, ARR);
    chk("R1 idle ready", {15'd0, r}, 16'd1);
  endtask

  task automatic t_prog;
    logic [DW-1:0] d; logic r;
    prog_dq7 = 1'b1;
    @(negedge clk); op_state = 3'd1;
    #3;
    chk("R8 busy in first cycle", {15'd0, ready}, 16'd0);
    chk("R8 toggles 0 in first cycle", dq, stat(1'b0, 1'b0, 1'b0));
    do_read(d, r);
    chk("R2 R11 prog read1", d, stat(1'b0, 1'b0, 1'b0));
    chk("R2 prog busy", {15'd0, r}, 16'd0);
    do_read(d, r);
    chk("R3 prog read2", d, stat(1'b0, 1'b1, 1'b0));
    idle_cycles(3);
    #3;
    chk("R3 no toggle without strobe", dq, stat(1'b0, 1'b0, 1'b0));
    do_read(d, r);
    chk("R3 prog read3", d, stat(1'b0, 1'b0, 1'b0));
    do_read(d, r);
    chk("R3 prog read4", d, stat(1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_done;
    logic [DW-1:0] d; logic r;
    set_op(3'd0);
    do_read(d, r);
    chk("R9 done read1", d, ARR);
    chk("R9 done ready", {15'd0, r}, 16'd1);
    do_read(d, r);
    chk("R9 done read2", d, ARR);
  endtask

  task automatic t_erase;
    logic [DW-1:0] d; logic r;
    set_op(3'd2);
    do_read(d, r);
    chk("R4 erase read1", d, stat(1'b0, 1'b0, 1'b0));
    chk("R4 erase busy", {15'd0, r}, 16'd0);
    do_read(d, r);
    chk("R4 erase read2", d, stat(1'b0, 1'b1, 1'b1));
    idle_cycles(2);
    do_read(d, r);
    chk("R4 erase read3", d, stat(1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_susp;
    logic [DW-1:0] d; logic r;
    in_susp = 1'b1;
    set_op(3'd3);
    do_read(d, r);
    chk("R5 R8 susp in read1", d, stat(1'b1, 1'b1, 1'b0));
    chk("R5 susp ready", {15'd0, r}, 16'd1);
    do_read(d, r);
    chk("R5 susp in read2", d, stat(1'b1, 1'b1, 1'b1));
    do_read(d, r);
    chk("R5 susp in read3", d, stat(1'b1, 1'b1, 1'b0));
    @(negedge clk); in_susp = 1'b0;
    do_read(d, r);
    chk("R6 susp out data", d, ARR);
    chk("R6 susp out ready", {15'd0, r}, 16'd1);
    @(negedge clk); in_susp = 1'b1;
    do_read(d, r);
    chk("R6 outside read left toggle alone", d, stat(1'b1, 1'b1, 1'b1));
  endtask

  task automatic t_susp_prog;
    logic [DW-1:0] d; logic r;
    prog_dq7 = 1'b0;
    set_op(3'd4);
    do_read(d, r);
    chk("R7 sprog read1", d, stat(1'b1, 1'b0, 1'b0));
    chk("R7 sprog busy", {15'd0, r}, 16'd0);
    do_read(d, r);
    chk("R7 sprog read2", d, stat(1'b1, 1'b1, 1'b0));
    do_read(d, r);
    chk("R7 sprog read3", d, stat(1'b1, 1'b0, 1'b0));
  endtask

  initial begin
    t_reset();
    t_idle();
    t_prog();
    t_done();
    t_erase();
    t_susp();
    t_susp_prog();
    set_op(3'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule